// File: doc/BRIEF.md
# Audio Serial Slave Start Synchronizer

This block decides the moment at which an audio serial port operating as a slave may begin shifting data. It runs on the system clock. It brings the external bit clock (`sck_in`) and word-select line (`ws_in`) into that clock domain through a parameterised synchronizer chain. On each bit-clock rising edge it takes one sample of the word-select level. From the configuration inputs (port mode, enable, asynchronous start, framing standard, role) it decides when a transfer may begin. It then raises a start strobe and a running flag that a separate shift engine uses to line up with a frame boundary. It also reports which channel the first word belongs to.

The controller has five states:
- `ST_IDLE`: inactive.
- `ST_ARM`: enabled, waiting for the first bit-clock edge.
- `ST_HUNT`: a reference word-select sample is held, and the block watches for the qualifying transition.
- `ST_START`: the strobe is high for one bit-clock period.
- `ST_RUN`: transferring.

The transitions are:
- IDLE→ARM when the block becomes active.
- ARM→START on the first bit-clock edge if asynchronous start is set.
- ARM→HUNT on that edge otherwise, which captures the reference sample.
- HUNT→START on a bit-clock edge that shows the qualifying word-select transition.
- START→RUN on the next bit-clock edge.
- Any state→IDLE as soon as the block is no longer active.

The framing standard code selects the transition that qualifies:
- `2'b00` (Philips-style) qualifies on a falling word-select edge.
- `2'b01` (left-justified), `2'b10` (right-justified) and `2'b11` (PCM) qualify on a rising edge.

The role code works as follows:
- Bit 1 high (`2'b10`, `2'b11`) marks a master role, and the block stays inactive.
- `2'b00` (slave transmit) and `2'b01` (slave receive) both let the block act.

Top module: `aud_slave_start_sync`

## Requirements
- R1: After reset `start_pulse`, `running` and `first_chan` are all 0.
- R2: With standard `2'b00` and asynchronous start off, the transfer starts on the bit-clock edge whose word-select sample is 0 while the previous sample was 1. A rising word-select edge does not start it.
- R3: With standard `2'b01`, `2'b10` or `2'b11` and asynchronous start off, the transfer starts on the bit-clock edge whose word-select sample is 1 while the previous sample was 0. A falling edge does not start it.
- R4: With asynchronous start on, the transfer starts on the first bit-clock rising edge after activation, whatever the word-select level. `first_chan` then equals the word-select level sampled on that edge.
- R5: Role codes `2'b10` and `2'b11` never produce a start. Role codes `2'b00` and `2'b01` both do.
- R6: While the port-mode input or the enable input is 0, both outputs stay 0, even with asynchronous start on and bit-clock edges arriving.
- R7: The first word-select sample after activation only sets the reference level. A steady word-select level never produces a start, whatever level it holds at activation.
- R8: `start_pulse` rises on the qualifying bit-clock edge, stays high through the following low phase of the bit clock, and falls on the next bit-clock rising edge, while `running` stays 1.
- R9: `running` stays 1 until enable is cleared. Clearing enable returns both outputs to 0. After re-enabling, a fresh qualifying transition is needed for a new start.
- R10: On a word-select edge start, `first_chan` equals the new word-select level: 0 after a falling edge, 1 after a rising edge.
- R11: The PCM frame-sync length input has no effect on when a transfer starts or on `first_chan`.
- R12: Without bit-clock edges no start occurs, even if word-select toggles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck_in | input | 1 | External bit clock from the master |
| ws_in | input | 1 | External word-select line |
| cfg_audio_mode | input | 1 | 1 selects the audio serial mode of the port |
| cfg_enable | input | 1 | Audio port enable |
| cfg_async_start | input | 1 | 1 starts on the first bit clock without a word-select check |
| cfg_std | input | 2 | Framing standard: 00 Philips-style, 01 left-justified, 10 right-justified, 11 PCM |
| cfg_role | input | 2 | 00 slave tx, 01 slave rx, 10 master tx, 11 master rx |
| cfg_pcm_long | input | 1 | PCM frame-sync length select (no effect on start) |
| start_pulse | output | 1 | High for one bit-clock period from the start edge |
| running | output | 1 | Set at start, held until disable |
| first_chan | output | 1 | Channel of the first word (word-select level at start) |

## Verification
A bit-clock rising edge applied at the pins reaches the outputs on the third system-clock edge after it arrives. Two of those edges are the synchronizer stages and one is the controller register, so the latency is `SYNC_STAGES`+1 edges. The same latency applies to word-select, because word-select travels through the same chain alongside the bit clock. Loss of enable clears the outputs on the next system-clock edge. The bench changes word-select only while the bit clock is low. It holds each bit-clock level for six system-clock cycles and samples at the falling system-clock edge just before the next bit-clock change, so every expected value is already settled when it is read.

// File: rtl/aud_start_pkg.sv
package aud_start_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_ARM   = 3'd1,
        ST_HUNT  = 3'd2,
        ST_START = 3'd3,
        ST_RUN   = 3'd4
    } start_state_t;

    typedef enum logic [1:0] {
        STD_PHILIPS = 2'b00,
        STD_LEFT    = 2'b01,
        STD_RIGHT   = 2'b10,
        STD_PCM     = 2'b11
    } frame_std_t;

    // role bit 1 set means master; this block acts only for slave roles
    localparam int ROLE_MASTER_BIT = 1;

endpackage

// File: rtl/aud_sync_chain.sv
module aud_sync_chain #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    generate
        if (STAGES == 1) begin : g_single
            logic [WIDTH-1:0] stage_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q <= '0;
                else        stage_q <= din;
            end
            assign dout = stage_q;
        end else begin : g_multi
            logic [STAGES-1:0][WIDTH-1:0] stage_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q <= '0;
                else        stage_q <= {stage_q[STAGES-2:0], din};
            end
            assign dout = stage_q[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/aud_bclk_sampler.sv
module aud_bclk_sampler #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck_in,
    input  logic ws_in,
    output logic sck_rise,
    output logic ws_level
);
    logic [1:0] synced;
    logic       sck_prev_q;

    aud_sync_chain #(
        .WIDTH  (2),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({sck_in, ws_in}),
        .dout  (synced)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sck_prev_q <= 1'b0;
        else        sck_prev_q <= synced[1];
    end

    assign sck_rise = synced[1] & ~sck_prev_q;
    assign ws_level = synced[0];

    // a bit-clock edge is reported for a single system cycle
    assert_rise_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        sck_rise |=> !sck_rise);

endmodule

// File: rtl/aud_start_fsm.sv
module aud_start_fsm
    import aud_start_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       active,
    input  logic       async_en,
    input  frame_std_t std_sel,
    input  logic       sck_rise,
    input  logic       ws_level,
    output logic       start_pulse,
    output logic       running,
    output logic       first_chan
);
    start_state_t state_q, state_d;
    logic         ws_prev_q, ws_prev_d;
    logic         chan_q, chan_d;
    logic         edge_ok;

    always_comb begin
        if (std_sel == STD_PHILIPS) edge_ok = ws_prev_q & ~ws_level;
        else                        edge_ok = ~ws_prev_q & ws_level;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            ws_prev_q <= 1'b0;
            chan_q    <= 1'b0;
        end else begin
            state_q   <= state_d;
            ws_prev_q <= ws_prev_d;
            chan_q    <= chan_d;
        end
    end

    // next state
    always_comb begin
        state_d   = state_q;
        ws_prev_d = ws_prev_q;
        chan_d    = chan_q;
        unique case (state_q)
            ST_IDLE: begin
                chan_d = 1'b0;
                if (active) state_d = ST_ARM;
            end
            ST_ARM: begin
                if (sck_rise) begin
                    if (async_en) begin
                        state_d = ST_START;
                        chan_d  = ws_level;
                    end else begin
                        ws_prev_d = ws_level;
                        state_d   = ST_HUNT;
                    end
                end
            end
            ST_HUNT: begin
                if (sck_rise) begin
                    ws_prev_d = ws_level;
                    if (edge_ok) begin
                        state_d = ST_START;
                        chan_d  = ws_level;
                    end
                end
            end
            ST_START: begin
                if (sck_rise) state_d = ST_RUN;
            end
            ST_RUN: begin
                state_d = ST_RUN;
            end
            default: state_d = ST_IDLE;
        endcase
        if (!active) state_d = ST_IDLE;
    end

    // outputs
    always_comb begin
        start_pulse = (state_q == ST_START);
        running     = (state_q == ST_START) || (state_q == ST_RUN);
        first_chan  = chan_q;
    end

    assert_idle_when_inactive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> (state_q == ST_IDLE));

    assert_start_on_sample_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(start_pulse) |-> $past(sck_rise));

    assert_falling_qualifies_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(start_pulse) && !$past(async_en) && ($past(std_sel) == STD_PHILIPS))
        |-> ($past(ws_prev_q) && !$past(ws_level)));

    assert_rising_qualifies_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(start_pulse) && !$past(async_en) && ($past(std_sel) != STD_PHILIPS))
        |-> (!$past(ws_prev_q) && $past(ws_level)));

    assert_async_from_arm_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(start_pulse) && ($past(state_q) == ST_ARM)) |-> $past(async_en));

    assert_strobe_one_bitclk_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(start_pulse) |-> ($past(sck_rise) || !$past(active)));

    assert_running_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (running && active) |=> running);

    assert_chan_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (running && active) |=> $stable(first_chan));

endmodule

// File: rtl/aud_slave_start_sync.sv
module aud_slave_start_sync
    import aud_start_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sck_in,
    input  logic       ws_in,
    input  logic       cfg_audio_mode,
    input  logic       cfg_enable,
    input  logic       cfg_async_start,
    input  logic [1:0] cfg_std,
    input  logic [1:0] cfg_role,
    input  logic       cfg_pcm_long,
    output logic       start_pulse,
    output logic       running,
    output logic       first_chan
);
    logic sck_rise;
    logic ws_level;
    logic active;
    logic [1:0] unused_cfg;

    // frame-sync length and the tx/rx role bit do not affect start timing
    assign unused_cfg = {cfg_pcm_long, cfg_role[0]};

    assign active = cfg_audio_mode & cfg_enable & ~cfg_role[ROLE_MASTER_BIT];

    aud_bclk_sampler #(
        .SYNC_STAGES (SYNC_STAGES)
    ) u_sampler (
        .clk      (clk),
        .rst_n    (rst_n),
        .sck_in   (sck_in),
        .ws_in    (ws_in),
        .sck_rise (sck_rise),
        .ws_level (ws_level)
    );

    aud_start_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .active      (active),
        .async_en    (cfg_async_start),
        .std_sel     (frame_std_t'(cfg_std)),
        .sck_rise    (sck_rise),
        .ws_level    (ws_level),
        .start_pulse (start_pulse),
        .running     (running),
        .first_chan  (first_chan)
    );

    assert_master_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_role[ROLE_MASTER_BIT] |=> (!running && !start_pulse));

    assert_mode_off_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_audio_mode && cfg_enable) |=> (!running && !start_pulse));

endmodule

// File: tb/aud_slave_start_sync_tb.sv
`timescale 1ns/1ps
module aud_slave_start_sync_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sck_in = 1'b0;
    logic       ws_in = 1'b0;
    logic       cfg_audio_mode = 1'b0;
    logic       cfg_enable = 1'b0;
    logic       cfg_async_start = 1'b0;
    logic [1:0] cfg_std = 2'b00;
    logic [1:0] cfg_role = 2'b00;
    logic       cfg_pcm_long = 1'b0;
    logic       start_pulse;
    logic       running;
    logic       first_chan;

    int n_checks = 0;
    int n_errors = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    aud_slave_start_sync u_dut (
        .clk             (clk),
        .rst_n           (rst_n),
        .sck_in          (sck_in),
        .ws_in           (ws_in),
        .cfg_audio_mode  (cfg_audio_mode),
        .cfg_enable      (cfg_enable),
        .cfg_async_start (cfg_async_start),
        .cfg_std         (cfg_std),
        .cfg_role        (cfg_role),
        .cfg_pcm_long    (cfg_pcm_long),
        .start_pulse     (start_pulse),
        .running         (running),
        .first_chan      (first_chan)
    );

    // vector: {std[13:12], async[11], role[10:9], pcm_long[8], ws per bit clock[7:4], start index[3:1] (7 = none), chan[0]}
    localparam logic [13:0] VEC [12] = '{
        {2'b00, 1'b0, 2'b00, 1'b0, 4'b0011, 3'd2, 1'b0},
        {2'b00, 1'b0, 2'b00, 1'b0, 4'b0110, 3'd3, 1'b0},
        {2'b01, 1'b0, 2'b00, 1'b0, 4'b1100, 3'd2, 1'b1},
        {2'b10, 1'b0, 2'b00, 1'b0, 4'b1101, 3'd2, 1'b1},
        {2'b11, 1'b0, 2'b00, 1'b0, 4'b1111, 3'd7, 1'b0},
        {2'b00, 1'b0, 2'b00, 1'b0, 4'b0000, 3'd7, 1'b0},
        {2'b00, 1'b1, 2'b00, 1'b0, 4'b0001, 3'd0, 1'b1},
        {2'b01, 1'b1, 2'b00, 1'b0, 4'b0010, 3'd0, 1'b0},
        {2'b11, 1'b0, 2'b01, 1'b0, 4'b0010, 3'd1, 1'b1},
        {2'b00, 1'b0, 2'b10, 1'b0, 4'b0001, 3'd7, 1'b0},
        {2'b00, 1'b1, 2'b11, 1'b0, 4'b0000, 3'd7, 1'b0},
        {2'b11, 1'b0, 2'b00, 1'b1, 4'b0010, 3'd1, 1'b1}
    };
    string vec_req [12] = '{"R2", "R2", "R3", "R3", "R7", "R7",
                            "R4", "R4", "R5", "R5", "R5", "R11"};

    task automatic check(input string req, input string what, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual=%0b expected=%0b", req, what, act, exp);
        end
    endtask

    task automatic idle_clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bclk_high(input logic ws_val);
        ws_in = ws_val;
        idle_clks(3);
        sck_in = 1'b1;
        idle_clks(6);
    endtask

    task automatic bclk_low();
        sck_in = 1'b0;
        idle_clks(6);
    endtask

    task automatic disable_all();
        cfg_enable = 1'b0;
        sck_in = 1'b0;
        idle_clks(6);
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000 && !done) begin
            done = 1'b1;
            n_errors++;
            n_checks++;
            $display("FAIL watchdog: actual=expired expected=finished");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        idle_clks(4);
        // R1: reset values
        check("R1", "start_pulse after reset", start_pulse, 1'b0);
        check("R1", "running after reset", running, 1'b0);
        check("R1", "first_chan after reset", first_chan, 1'b0);
        rst_n = 1'b1;
        idle_clks(4);

        // table walk
        for (int v = 0; v < 12; v++) begin
            logic [13:0] e;
            logic [3:0]  wsq;
            int          k;
            e   = VEC[v];
            wsq = e[7:4];
            k   = int'(e[3:1]);
            cfg_std         = e[13:12];
            cfg_async_start = e[11];
            cfg_role        = e[10:9];
            cfg_pcm_long    = e[8];
            cfg_audio_mode  = 1'b1;
            ws_in           = wsq[0];
            idle_clks(3);
            cfg_enable = 1'b1;
            idle_clks(3);
            for (int i = 0; i < 5; i++) begin
                bclk_high((i < 4) ? wsq[i] : wsq[3]);
                check(vec_req[v], $sformatf("vec %0d start_pulse at bit clock %0d", v, i),
                      start_pulse, (i == k));
                if (i == k + 1) begin
                    // R8: strobe has dropped at the next rising bit-clock edge
                    check("R8", "strobe low after next bit clock", start_pulse, 1'b0);
                    check("R8", "running kept after strobe", running, 1'b1);
                end
                bclk_low();
                if (i == k)
                    check("R8", "strobe held through low phase", start_pulse, 1'b1);
            end
            check(vec_req[v], $sformatf("vec %0d running", v), running, (k != 7));
            if (k != 7)
                check("R10", $sformatf("vec %0d first_chan", v), first_chan, e[0]);
            disable_all();
        end

        // R6: mode off, then enable off, with asynchronous start and bit clocks
        cfg_role = 2'b00; cfg_std = 2'b00; cfg_async_start = 1'b1; cfg_pcm_long = 1'b0;
        cfg_audio_mode = 1'b0; cfg_enable = 1'b1;
        idle_clks(3);
        bclk_high(1'b1); bclk_low(); bclk_high(1'b0);
        check("R6", "running with mode off", running, 1'b0);
        check("R6", "start_pulse with mode off", start_pulse, 1'b0);
        bclk_low();
        cfg_audio_mode = 1'b1; cfg_enable = 1'b0;
        idle_clks(3);
        bclk_high(1'b1); bclk_low(); bclk_high(1'b0);
        check("R6", "running with enable off", running, 1'b0);
        bclk_low();

        // R12: word-select toggles with no bit clock
        cfg_async_start = 1'b0; cfg_std = 2'b00; cfg_enable = 1'b1;
        idle_clks(3);
        for (int i = 0; i < 6; i++) begin
            ws_in = ~ws_in;
            idle_clks(8);
        end
        check("R12", "running without bit clock", running, 1'b0);
        check("R12", "start_pulse without bit clock", start_pulse, 1'b0);
        disable_all();

        // R9: run, disable, re-enable needs a fresh edge
        cfg_std = 2'b01; ws_in = 1'b0;
        idle_clks(3);
        cfg_enable = 1'b1;
        idle_clks(3);
        bclk_high(1'b0); bclk_low();
        bclk_high(1'b1); bclk_low();
        check("R9", "running after start", running, 1'b1);
        for (int i = 0; i < 3; i++) begin
            bclk_high(i[0]); bclk_low();
        end
        check("R9", "running held while enabled", running, 1'b1);
        cfg_enable = 1'b0;
        idle_clks(4);
        check("R9", "running cleared by disable", running, 1'b0);
        check("R9", "start_pulse cleared by disable", start_pulse, 1'b0);
        ws_in = 1'b1;
        idle_clks(3);
        cfg_enable = 1'b1;
        idle_clks(3);
        bclk_high(1'b1); bclk_low();
        bclk_high(1'b1); bclk_low();
        check("R9", "no restart with steady level", running, 1'b0);
        bclk_high(1'b0); bclk_low();
        check("R9", "no restart on falling edge", running, 1'b0);
        bclk_high(1'b1);
        check("R9", "restart strobe on fresh edge", start_pulse, 1'b1);
        check("R10", "first_chan after rising restart", first_chan, 1'b1);
        bclk_low();
        disable_all();

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule